// File: doc/BRIEF.md
# GPIO Input Change Interrupt Controller

This block watches a set of general-purpose inputs that have already been synchronised to the local clock. Each input has a programmable expected level. When an input pin moves away from that level, the block records the event in a sticky status bit. It then drives an active-low interrupt request, which the pad turns into an open-drain pull-down. Software services the request by reading the status register. That read returns the pending bits and clears them in the same cycle.

Detection is edge-qualified against the expected level, not against every toggle. After a status bit has been cleared, it stays clear while the input remains away from its expected level. The input must first come back to the expected level and then leave it again before the bit can set once more. Pins that are configured as outputs take no part in detection. A separate reset-indication flag from the surrounding logic also drives the request. Register access uses a simple single-cycle bus: reads are combinational on the address, and writes and clearing reads take effect at the clock edge.

Top module: `gpio_chg_irq`

## Requirements
- R1: After reset, the direction (addr 0), expected-level (addr 1), mask (addr 2) and status (addr 4) registers all read 0x00. With `rst_flag_i` low, `irq_no` is high.
- R2: A pin whose direction bit is 0 sets its status bit at the first clock edge at which `gpio_i` differs from its expected-level bit. An expected level of 0 triggers on a high input, and an expected level of 1 triggers on a low input.
- R3: A read at addr 4 (`rd_i` high) returns the status bits on `rdata_o`. At that same edge it clears every status bit whose input is not newly departing. Status bits otherwise hold their value.
- R4: If a pin is still away from its expected level after its status bit is cleared, the bit stays 0. It can set again only after the pin has returned to the expected level for at least one edge and then departs again.
- R5: If a pin departs at the same edge as a clearing read of addr 4, its status bit is 1 after that edge.
- R6: A mask bit of 1 keeps its status bit from driving `irq_no`, but the status bit is still recorded. A mask bit of 0 lets it drive `irq_no`.
- R7: `irq_no` is registered. It is low in the cycle after any status bit with mask 0 is set, or after `rst_flag_i` is high. Otherwise it is high in the cycle after.
- R8: A pin whose direction bit is 1 never sets its status bit, whatever its level.
- R9: A read at addr 3 returns the live level of `gpio_i` on all pins.
- R10: Writes to addr 3 and addr 4 have no effect, and reads at addresses 5 to 7 return 0x00.
- R11: Writes to addr 0, 1 and 2 take effect at the clock edge and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gpio_i | input | 8 | Synchronised pin levels |
| rst_flag_i | input | 1 | Reset-indication flag that also drives the request |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (makes addr 4 clear) |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational on `addr_i` |
| irq_no | output | 1 | Interrupt request, active low |

## Verification
The hardest case to reach from the ports is a fresh departure that lands on exactly the edge of the clearing read. The bench changes a second pin in the same half-cycle in which it raises the read strobe. It then checks two things: the read returns only the old bit, and a follow-up read returns the new one. The re-arm rule is reached by holding a pin away from its expected level across several clearing reads, then toggling it back and out again. The vector table sweeps direction, expected-level and mask combinations, so that output pins, masked pins and both polarities each appear.

// File: rtl/gpio_chg_pkg.sv
package gpio_chg_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_DIR    = 3'd0,
    SEL_EXPECT = 3'd1,
    SEL_MASK   = 3'd2,
    SEL_LEVEL  = 3'd3,
    SEL_STATUS = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/gpio_chg_regs.sv
module gpio_chg_regs
  import gpio_chg_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N-1:0]      wdata_i,
  input  logic [N-1:0]      level_i,
  input  logic [N-1:0]      status_i,
  output logic [N-1:0]      rdata_o,
  output logic [N-1:0]      dir_o,
  output logic [N-1:0]      expect_o,
  output logic [N-1:0]      mask_o,
  output logic              clr_o
);
  logic [N-1:0] dir_q, expect_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q    <= '0;
      expect_q <= '0;
      mask_q   <= '0;
    end else if (wr_i) begin
      case (addr_i)
        SEL_DIR:    dir_q    <= wdata_i;
        SEL_EXPECT: expect_q <= wdata_i;
        SEL_MASK:   mask_q   <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      SEL_DIR:    rdata_o = dir_q;
      SEL_EXPECT: rdata_o = expect_q;
      SEL_MASK:   rdata_o = mask_q;
      SEL_LEVEL:  rdata_o = level_i;
      SEL_STATUS: rdata_o = status_i;
      default:    rdata_o = '0;
    endcase
  end

  assign clr_o    = rd_i && (addr_i == SEL_STATUS);
  assign dir_o    = dir_q;
  assign expect_o = expect_q;
  assign mask_o   = mask_q;
endmodule

// File: rtl/gpio_chg_detect.sv
module gpio_chg_detect #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] gpio_i,
  input  logic [N-1:0] dir_i,
  input  logic [N-1:0] expect_i,
  input  logic         clr_i,
  output logic [N-1:0] status_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic away, armed_q, stat_q;

    // output pins never count as away
    assign away = ~dir_i[g] & (gpio_i[g] ^ expect_i[g]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        armed_q <= 1'b1;
        stat_q  <= 1'b0;
      end else begin
        armed_q <= ~away;
        // new departure wins over a same-edge clear
        stat_q  <= (away & armed_q) | (stat_q & ~clr_i);
      end
    end

    assign status_o[g] = stat_q;
  end
endmodule

// File: rtl/gpio_chg_req.sv
module gpio_chg_req #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] status_i,
  input  logic [N-1:0] mask_i,
  input  logic         rst_flag_i,
  output logic         irq_no
);
  logic req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= (|(status_i & ~mask_i)) | rst_flag_i;
  end

  assign irq_no = ~req_q;
endmodule

// File: rtl/gpio_chg_irq.sv
module gpio_chg_irq
  import gpio_chg_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N-1:0]      gpio_i,
  input  logic              rst_flag_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N-1:0]      wdata_i,
  output logic [N-1:0]      rdata_o,
  output logic              irq_no
);
  logic [N-1:0] dir_w, expect_w, mask_w, status_w;
  logic         clr_w;

  gpio_chg_regs #(.N(N)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_i),
    .rd_i     (rd_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .level_i  (gpio_i),
    .status_i (status_w),
    .rdata_o  (rdata_o),
    .dir_o    (dir_w),
    .expect_o (expect_w),
    .mask_o   (mask_w),
    .clr_o    (clr_w)
  );

  gpio_chg_detect #(.N(N)) u_detect (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .gpio_i   (gpio_i),
    .dir_i    (dir_w),
    .expect_i (expect_w),
    .clr_i    (clr_w),
    .status_o (status_w)
  );

  gpio_chg_req #(.N(N)) u_req (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .status_i   (status_w),
    .mask_i     (mask_w),
    .rst_flag_i (rst_flag_i),
    .irq_no     (irq_no)
  );
endmodule

// File: rtl/gpio_chg_irq_chk.sv
module gpio_chg_irq_chk
  import gpio_chg_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N-1:0]      gpio_i,
  input logic              rst_flag_i,
  input logic              rd_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [N-1:0]      rdata_o,
  input logic              irq_no,
  input logic [N-1:0]      dir,
  input logic [N-1:0]      expect_lvl,
  input logic [N-1:0]      mask,
  input logic [N-1:0]      status
);
  logic rd_stat;
  assign rd_stat = rd_i && (addr_i == SEL_STATUS);

  assert_irq_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|(status & ~mask)) || rst_flag_i) |=> !irq_no);

  assert_irq_high_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(|(status & ~mask)) && !rst_flag_i) |=> irq_no);

  assert_level_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == SEL_LEVEL) |-> (rdata_o == gpio_i));

  for (genvar g = 0; g < N; g++) begin : g_chk
    logic away;
    assign away = ~dir[g] & (gpio_i[g] ^ expect_lvl[g]);

    assert_set_cause_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!away && !status[g]) |=> !status[g]);

    assert_output_pin_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dir[g] && !status[g]) |=> !status[g]);

    assert_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (status[g] && !rd_stat) |=> status[g]);

    assert_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_stat && !away) |=> !status[g]);
  end
endmodule

bind gpio_chg_irq gpio_chg_irq_chk #(.N(N)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .gpio_i     (gpio_i),
  .rst_flag_i (rst_flag_i),
  .rd_i       (rd_i),
  .addr_i     (addr_i),
  .rdata_o    (rdata_o),
  .irq_no     (irq_no),
  .dir        (dir_w),
  .expect_lvl (expect_w),
  .mask       (mask_w),
  .status     (status_w)
);

// File: tb/gpio_chg_irq_test.sv
module gpio_chg_irq_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] gpio = 8'h00;
  logic       rst_flag = 1'b0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq_n;

  int chk_cnt = 0;
  int fail_cnt = 0;
  int cyc = 0;
  bit done = 1'b0;

  localparam logic [2:0] A_DIR = 3'd0, A_EXP = 3'd1, A_MASK = 3'd2,
                         A_LVL = 3'd3, A_STAT = 3'd4;

  // {dir, expected, mask, gpio}
  localparam logic [31:0] VECS [7] = '{
    32'h00_00_00_01, 32'h00_FF_00_7F, 32'hF0_00_00_FF, 32'h00_00_FF_55,
    32'h0F_A5_0F_5A, 32'hFF_00_00_FF, 32'h00_3C_C0_FC
  };

  gpio_chg_irq #(.N(8)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .gpio_i(gpio), .rst_flag_i(rst_flag),
    .wr_i(wr), .rd_i(rd), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_no(irq_n)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      chk_cnt = chk_cnt + 1;
      fail_cnt = fail_cnt + 1;
      $display("FAIL watchdog: actual cycle %0d expected finish", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", chk_cnt, fail_cnt);
      $finish;
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    chk_cnt = chk_cnt + 1;
    if (act !== exp) begin
      fail_cnt = fail_cnt + 1;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    tick();
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    tick();
    rd = 1'b0;
  endtask

  initial begin
    logic [7:0] v;
    #25 rst_ni = 1'b1;
    tick();

    // R1 reset state
    check("R1 irq", {7'd0, irq_n}, 8'h01);
    rd_reg(A_DIR, v);  check("R1 dir", v, 8'h00);
    rd_reg(A_EXP, v);  check("R1 expected", v, 8'h00);
    rd_reg(A_MASK, v); check("R1 mask", v, 8'h00);
    rd_reg(A_STAT, v); check("R1 status", v, 8'h00);

    // R11 readback
    wr_reg(A_DIR, 8'h5A);  rd_reg(A_DIR, v);  check("R11 dir", v, 8'h5A);
    wr_reg(A_EXP, 8'hC3);  rd_reg(A_EXP, v);  check("R11 expected", v, 8'hC3);
    wr_reg(A_MASK, 8'h96); rd_reg(A_MASK, v); check("R11 mask", v, 8'h96);

    // vector table: R2 R6 R7 R8
    for (int i = 0; i < 7; i++) begin
      logic [7:0] d, e, m, g, st;
      {d, e, m, g} = VECS[i];
      st = ~d & (g ^ e);
      wr_reg(A_DIR, d); wr_reg(A_EXP, e); wr_reg(A_MASK, m);
      gpio = e; tick();
      rd_reg(A_STAT, v); tick();
      gpio = g; tick(); tick();
      check($sformatf("R7 vec%0d irq", i), {7'd0, irq_n}, {7'd0, ~(|(st & ~m))});
      rd_reg(A_STAT, v);
      check($sformatf("R2 R8 vec%0d status", i), v, st);
    end

    // R4 re-arm only after return to expected level
    wr_reg(A_DIR, 8'h00); wr_reg(A_EXP, 8'h00); wr_reg(A_MASK, 8'h00);
    gpio = 8'h00; tick(); rd_reg(A_STAT, v);
    gpio = 8'h01; tick();
    rd_reg(A_STAT, v); check("R4 first set", v, 8'h01);
    rd_reg(A_STAT, v); check("R4 held away, cleared", v, 8'h00);
    tick(); tick();
    rd_reg(A_STAT, v); check("R4 still clear", v, 8'h00);
    tick();
    check("R4 irq released", {7'd0, irq_n}, 8'h01);
    gpio = 8'h00; tick();
    gpio = 8'h01; tick();
    rd_reg(A_STAT, v); check("R4 re-set after return", v, 8'h01);

    // R5 departure on the clearing edge
    gpio = 8'h00; tick();
    gpio = 8'h01; tick();
    gpio = 8'h03;
    rd_reg(A_STAT, v); check("R5 read value", v, 8'h01);
    tick();
    check("R5 irq kept", {7'd0, irq_n}, 8'h00);
    rd_reg(A_STAT, v); check("R5 new bit kept", v, 8'h02);

    // R6 masked bit records but does not request
    gpio = 8'h00; tick(); rd_reg(A_STAT, v);
    wr_reg(A_MASK, 8'h01);
    gpio = 8'h01; tick(); tick();
    check("R6 masked irq", {7'd0, irq_n}, 8'h01);

    // R10 status write ignored
    wr_reg(A_STAT, 8'h00);
    rd_reg(A_STAT, v); check("R6 R10 status kept", v, 8'h01);

    // R7 reset-indication flag
    tick();
    rst_flag = 1'b1; tick();
    check("R7 flag low", {7'd0, irq_n}, 8'h00);
    rst_flag = 1'b0; tick();
    check("R7 flag release", {7'd0, irq_n}, 8'h01);

    // R9 live level, R10 ignored write and unmapped reads
    wr_reg(A_DIR, 8'hFF);
    gpio = 8'hA5; #1;
    rd_reg(A_LVL, v); check("R9 level", v, 8'hA5);
    wr_reg(A_LVL, 8'h00);
    rd_reg(A_LVL, v); check("R10 level write ignored", v, 8'hA5);
    gpio = 8'h3C; #1;
    rd_reg(A_LVL, v); check("R9 level follows", v, 8'h3C);
    for (int a = 5; a < 8; a++) begin
      rd_reg(3'(a), v); check($sformatf("R10 unmapped %0d", a), v, 8'h00);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", chk_cnt, fail_cnt);
    $finish;
  end
endmodule